// File: doc/BRIEF.md
# Eight-Instruction Accumulator Processor Core

This block is a small 8-bit processor built around one accumulator. Every data operand is reached by direct addressing: the instruction itself carries the full 13-bit byte address of its operand. Instructions are 16 bits wide. They are read as two bytes over the 8-bit read-data input, from consecutive addresses starting at the program counter.

Each instruction runs through a fixed five-cycle sequence: high-byte fetch, low-byte fetch, decode, operand access and execute. Eight operations are supported: halt, skip-if-zero, add, and, xor, load, store and jump. The address space is split. Bytes 0x0000 to 0x17FF hold program ROM and bytes 0x1800 to 0x1FFF hold read/write RAM. The memories and the ROM/RAM select decoder sit outside the core, which only drives the address, a read strobe, a write strobe and a separate store-data output.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the core presents a fetch at address 0x0000: `fetch`=1, `rd`=1, `wr`=0 and `halt`=0. The accumulator is cleared to 0x00.
- R2: An instruction is fetched in two consecutive cycles with `fetch`=1 and `rd`=1. The first cycle reads the program counter, which is even, and the second reads the program counter plus 1. The first byte holds the opcode in bits 7:5 and operand address bits 12:8 in bits 4:0. The second byte holds address bits 7:0. The opcodes are 000 halt, 001 skip-if-zero, 010 add, 011 and, 100 xor, 101 load, 110 store and 111 jump.
- R3: Every instruction other than halt takes exactly five cycles, so consecutive high-byte fetches are five cycles apart.
- R4: Add, and and xor combine the accumulator with the byte read from the operand address and write the result back to the accumulator. Addition wraps modulo 256, so 0xFF plus 0x01 gives 0x00.
- R5: Load copies the byte read from the operand address into the accumulator.
- R6: Store raises `wr` for exactly one cycle with `addr` equal to the operand address and `wdata` equal to the accumulator. `rd` is low in that cycle.
- R7: Skip-if-zero moves the program counter forward by 4 when the accumulator is zero and by 2 otherwise, and makes no operand access.
- R8: Jump loads the 13-bit operand address into the program counter and makes no operand access.
- R9: Halt raises `halt`, and it stays high with no further `rd` or `wr` activity until the next reset.
- R10: Skip-if-zero, store, jump and halt leave the accumulator unchanged.
- R11: `rd` is high only in the two fetch cycles and in the operand cycle of add, and, xor and load. `rd` and `wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rdata | input | 8 | Byte returned by memory for the current address |
| addr | output | 13 | Byte address for instruction or operand access |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe, one cycle per store |
| wdata | output | 8 | Store data, the accumulator while `wr` is high, zero otherwise |
| fetch | output | 1 | High during the two instruction fetch cycles |
| halt | output | 1 | High once a halt instruction has been decoded |

## Verification
The embedded properties check the following on every cycle: the paired fetch cycles and the +1 address of the low byte, the return to fetch after execute, and the single-cycle write strobe. They also check the exclusion of read and write, that skip, jump and halt make no operand access, that the accumulator is kept through non-arithmetic instructions, and that halt is sticky and silent. Only the bench's programs can show that arithmetic results are correct, including the modulo-256 wrap. The same holds for the skip distance of 2 versus 4 bytes, for jump targets, and for loops that end on a computed condition. For these checks a reference instruction model predicts every fetch, operand read, store and the final halt.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   // Opcode values are architectural: they occupy the top three bits of
   // the first instruction byte.
   typedef enum logic [2:0] {
      OP_HALT  = 3'b000,
      OP_SKZ   = 3'b001,
      OP_ADD   = 3'b010,
      OP_AND   = 3'b011,
      OP_XOR   = 3'b100,
      OP_LOAD  = 3'b101,
      OP_STORE = 3'b110,
      OP_JUMP  = 3'b111
   } op_e;

   typedef enum logic [2:0] {
      PH_FHI,   // fetch first instruction byte
      PH_FLO,   // fetch second instruction byte
      PH_DEC,   // decode
      PH_OPND,  // operand read or write
      PH_EXEC,  // accumulator and program counter update
      PH_STOP   // halted
   } phase_e;

   localparam int unsigned OPC_W = 3;

   function automatic logic op_reads(input op_e o);
      return (o == OP_ADD) || (o == OP_AND) || (o == OP_XOR) || (o == OP_LOAD);
   endfunction

endpackage

// File: rtl/acc_core_seq.sv
module acc_core_seq
   import acc_core_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  op_e    opcode,
   output phase_e phase
);

   phase_e phase_nxt;

   always_comb begin
      phase_nxt = phase;
      case (phase)
         PH_FHI:  phase_nxt = PH_FLO;
         PH_FLO:  phase_nxt = PH_DEC;
         PH_DEC:  phase_nxt = (opcode == OP_HALT) ? PH_STOP : PH_OPND;
         PH_OPND: phase_nxt = PH_EXEC;
         PH_EXEC: phase_nxt = PH_FHI;
         PH_STOP: phase_nxt = PH_STOP;
         default: phase_nxt = PH_FHI;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_FHI;
      else        phase <= phase_nxt;
   end

   // R2: the high-byte fetch is always followed by the low-byte fetch
   p_fetch_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_FHI |=> phase == PH_FLO);

   // R3: execute always hands over to the next fetch
   p_exec_to_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_EXEC |=> phase == PH_FHI);

   // R9: the stopped phase is left only by reset
   p_stop_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_STOP |=> phase == PH_STOP);

endmodule

// File: rtl/acc_core_pc.sv
module acc_core_pc
   import acc_core_pkg::*;
#(
   parameter int unsigned ADDR_W      = 13,
   parameter int unsigned INSTR_BYTES = 2,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase,
   input  op_e               opcode,
   input  logic              acc_zero,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc
);

   localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(INSTR_BYTES);
   localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2 * INSTR_BYTES);

   logic [ADDR_W-1:0] pc_nxt;

   always_comb begin
      pc_nxt = pc;
      if (phase == PH_EXEC) begin
         case (opcode)
            OP_JUMP: pc_nxt = target;
            OP_SKZ:  pc_nxt = pc + (acc_zero ? STEP_TWO : STEP_ONE);
            default: pc_nxt = pc + STEP_ONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= RESET_PC;
      else        pc <= pc_nxt;
   end

   // R3: the program counter moves only at the end of execute
   p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      phase != PH_EXEC |=> pc == $past(pc));

endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
   import acc_core_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  op_e               opcode,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] result,
   output logic              acc_zero
);

   logic [DATA_W-1:0] bit_res;
   logic [DATA_W-1:0] sum;

   // Bitwise operations are one identical slice per data bit.
   for (genvar b = 0; b < DATA_W; b++) begin : g_slice
      assign bit_res[b] = (opcode == OP_AND)  ? (acc[b] & opnd[b]) :
                          (opcode == OP_XOR)  ? (acc[b] ^ opnd[b]) :
                          (opcode == OP_LOAD) ? opnd[b] : acc[b];
   end

   // Modulo 2**DATA_W addition: the carry is discarded.
   assign sum      = acc + opnd;
   assign result   = (opcode == OP_ADD) ? sum : bit_res;
   assign acc_zero = (acc == '0);

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 13,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] addr,
   output logic              rd,
   output logic              wr,
   output logic [DATA_W-1:0] wdata,
   output logic              fetch,
   output logic              halt
);

   localparam int unsigned HI_ADDR_W   = ADDR_W - DATA_W;
   localparam int unsigned INSTR_BYTES = 2;

   if (OPC_W + ADDR_W != INSTR_BYTES * DATA_W) begin : g_bad_fmt
      $error("opcode plus address must fill exactly two data bytes");
   end
   if (ADDR_W <= DATA_W) begin : g_bad_addr
      $error("address must be wider than one data byte");
   end
   if (RESET_PC[0] != 1'b0) begin : g_bad_reset
      $error("reset program counter must be instruction aligned");
   end

   phase_e            phase;
   op_e               opcode;
   logic [DATA_W-1:0] ir_hi;
   logic [DATA_W-1:0] ir_lo;
   logic [DATA_W-1:0] opnd;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] alu_res;
   logic              acc_zero;
   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] target;

   assign opcode = op_e'(ir_hi[DATA_W-1 -: OPC_W]);
   assign target = {ir_hi[HI_ADDR_W-1:0], ir_lo};

   acc_core_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (opcode),
      .phase  (phase)
   );

   acc_core_pc #(
      .ADDR_W      (ADDR_W),
      .INSTR_BYTES (INSTR_BYTES),
      .RESET_PC    (RESET_PC)
   ) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .opcode   (opcode),
      .acc_zero (acc_zero),
      .target   (target),
      .pc       (pc)
   );

   acc_core_alu #(
      .DATA_W (DATA_W)
   ) u_alu (
      .opcode   (opcode),
      .acc      (acc),
      .opnd     (opnd),
      .result   (alu_res),
      .acc_zero (acc_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_hi <= '0;
         ir_lo <= '0;
         opnd  <= '0;
         acc   <= '0;
      end else begin
         case (phase)
            PH_FHI:  ir_hi <= rdata;
            PH_FLO:  ir_lo <= rdata;
            PH_OPND: if (op_reads(opcode)) opnd <= rdata;
            PH_EXEC: if (op_reads(opcode)) acc <= alu_res;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (phase)
         PH_FHI:  addr = pc;
         PH_FLO:  addr = pc + ADDR_W'(1);
         PH_OPND: addr = target;
         default: addr = pc;
      endcase
   end

   assign fetch = (phase == PH_FHI) || (phase == PH_FLO);
   assign rd    = fetch || ((phase == PH_OPND) && op_reads(opcode));
   assign wr    = (phase == PH_OPND) && (opcode == OP_STORE);
   assign wdata = wr ? acc : '0;
   assign halt  = (phase == PH_STOP);

   // R11: never read and write in the same cycle
   p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd && wr));

   // R6: a store strobes wr for a single cycle
   p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !wr);

   // R2: the second fetch byte comes from the next address
   p_lo_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_FLO |-> addr == $past(addr) + ADDR_W'(1));

   // R7, R8: skip, jump and halt make no operand access after decode
   p_no_opnd_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DEC && !op_reads(opcode) && opcode != OP_STORE) |=> (!rd && !wr));

   // R10: non-arithmetic instructions keep the accumulator
   p_acc_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC && !op_reads(opcode)) |=> acc == $past(acc));

   // R9: once halted the core stays quiet
   p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (halt && !rd && !wr));

endmodule

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;

   localparam int K_FETCH = 0, K_READ = 1, K_STORE = 2, K_HALT = 3;
   localparam logic [2:0] C_HLT = 3'b000, C_SKZ = 3'b001, C_ADD = 3'b010, C_AND = 3'b011,
                          C_XOR = 3'b100, C_LDA = 3'b101, C_STO = 3'b110, C_JMP = 3'b111;
   localparam logic [12:0] RAM_BASE = 13'h1800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rdata;
   logic [12:0] addr;
   logic        rd, wr, fetch, halt;
   logic [7:0]  wdata;

   logic [7:0] rom [0:255];
   logic [7:0] ram [0:15];

   typedef struct {
      int          kind;
      logic [12:0] a;
      logic [7:0]  d;
      string       tag;
   } item_t;
   item_t exp_q[$];

   int n_chk = 0, n_fail = 0;
   int last_start = -1;
   logic [12:0] last_fa = '0;
   bit halt_seen = 0, post_halt_access = 0;

   always #10 clk = ~clk;

   acc_core dut_i (
      .clk(clk), .rst_n(rst_n), .rdata(rdata), .addr(addr), .rd(rd),
      .wr(wr), .wdata(wdata), .fetch(fetch), .halt(halt)
   );

   always_comb rdata = (addr < RAM_BASE) ? rom[addr[7:0]] : ram[addr[3:0]];

   always @(posedge clk)
      if (rst_n && wr && addr >= RAM_BASE) ram[addr[3:0]] <= wdata;

   task automatic check(bit ok, string tag, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   task automatic report();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   task automatic pop_cmp(int kind, logic [12:0] a, logic [7:0] d);
      item_t it;
      if (exp_q.size() == 0) begin
         check(0, "R11", "unexpected bus event kind", kind, -1);
         return;
      end
      it = exp_q.pop_front();
      check(it.kind == kind, it.tag, "event kind", kind, it.kind);
      if (kind != K_HALT) check(it.a == a, it.tag, "address", a, it.a);
      if (kind == K_STORE) check(it.d == d, it.tag, "store data", d, it.d);
   endtask

   task automatic push(int kind, logic [12:0] a, logic [7:0] d, string tag);
      item_t it;
      it.kind = kind; it.a = a; it.d = d; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic put_ins(int at, logic [2:0] op, logic [12:0] t);
      rom[at]     = {op, t[12:8]};
      rom[at + 1] = t[7:0];
   endtask

   // Reference instruction model: predicts every bus event from the requirements.
   task automatic model_run();
      logic [7:0]  m_ram [0:15];
      logic [12:0] pc = '0;
      logic [7:0]  acc = '0;
      logic [7:0]  v;
      logic [2:0]  op;
      logic [12:0] t;
      for (int i = 0; i < 16; i++) m_ram[i] = ram[i];
      for (int step = 0; step < 400; step++) begin
         op = rom[pc[7:0]][7:5];
         t  = {rom[pc[7:0]][4:0], rom[pc[7:0] + 8'd1]};
         push(K_FETCH, pc, 8'h00, "R2 R7 R8");
         if (op == C_HLT) begin
            push(K_HALT, pc, 8'h00, "R9");
            return;
         end
         v = (t >= RAM_BASE) ? m_ram[t[3:0]] : rom[t[7:0]];
         case (op)
            C_SKZ: pc = pc + ((acc == 8'h00) ? 13'd4 : 13'd2);
            C_JMP: pc = t;
            C_STO: begin
               push(K_STORE, t, acc, "R4 R5 R6 R10");
               if (t >= RAM_BASE) m_ram[t[3:0]] = acc;
               pc = pc + 13'd2;
            end
            default: begin
               push(K_READ, t, 8'h00, "R11");
               case (op)
                  C_ADD:   acc = acc + v;
                  C_AND:   acc = acc & v;
                  C_XOR:   acc = acc ^ v;
                  default: acc = v;
               endcase
               pc = pc + 13'd2;
            end
         endcase
      end
   endtask

   // Monitor: samples just after each falling edge.
   initial begin
      int cyc = 0;
      forever begin
         @(negedge clk);
         #1;
         cyc++;
         if (rst_n) begin
            if (fetch && rd && !addr[0]) begin
               if (last_start >= 0) check(cyc - last_start == 5, "R3", "fetch spacing", cyc - last_start, 5);
               last_start = cyc;
               last_fa = addr;
               pop_cmp(K_FETCH, addr, 8'h00);
            end else if (fetch && rd) begin
               check(addr == last_fa + 13'd1, "R2", "low byte address", addr, last_fa + 13'd1);
            end else if (rd) begin
               pop_cmp(K_READ, addr, 8'h00);
            end
            if (wr) pop_cmp(K_STORE, addr, wdata);
            if (rd && wr) check(0, "R11", "rd with wr", 1, 0);
            if (halt && !halt_seen) begin
               halt_seen = 1;
               pop_cmp(K_HALT, addr, 8'h00);
            end else if (halt_seen && (rd || wr)) begin
               post_halt_access = 1;
            end
         end
      end
   end

   task automatic run_prog(string name);
      int waited = 0;
      @(negedge clk);
      rst_n = 1'b0;
      exp_q.delete();
      halt_seen = 0;
      post_halt_access = 0;
      last_start = -1;
      model_run();
      repeat (2) @(negedge clk);
      #1;
      check(addr == 13'h0000 && fetch && rd && !wr && !halt, "R1",
            {name, " reset outputs"}, {addr, fetch, rd, wr, halt}, {13'h0000, 4'b1100});
      @(negedge clk);
      rst_n = 1'b1;
      while (!halt_seen && waited < 5000) begin
         @(negedge clk);
         waited++;
      end
      repeat (8) @(negedge clk);
      #2;
      check(halt_seen && halt, "R9", {name, " halt reached"}, halt, 1);
      check(!post_halt_access, "R9", {name, " access after halt"}, post_halt_access, 0);
      check(exp_q.size() == 0, "R9 R11", {name, " events left"}, exp_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(0, "R3", "watchdog expired", 0, 1);
      report();
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) rom[i] = 8'h00;
      for (int i = 0; i < 16; i++) ram[i] = 8'h00;

      // Program 1: every opcode, add wrap, both skip outcomes, jump.
      ram[0] = 8'h00; ram[1] = 8'hFF; ram[2] = 8'h01; ram[3] = 8'hAA;
      put_ins(8'h00, C_LDA, RAM_BASE + 13'd1);   // acc = FF
      put_ins(8'h02, C_ADD, RAM_BASE + 13'd2);   // R4 wrap -> 00
      put_ins(8'h04, C_STO, RAM_BASE + 13'd4);   // store 00
      put_ins(8'h06, C_SKZ, 13'h0000);           // R7 zero: skip to 0A
      put_ins(8'h08, C_HLT, 13'h0000);
      put_ins(8'h0A, C_LDA, RAM_BASE + 13'd3);   // R5 acc = AA
      put_ins(8'h0C, C_AND, RAM_BASE + 13'd1);   // AA
      put_ins(8'h0E, C_XOR, RAM_BASE + 13'd1);   // 55
      put_ins(8'h10, C_STO, RAM_BASE + 13'd5);
      put_ins(8'h12, C_SKZ, 13'h0000);           // R7 nonzero: next
      put_ins(8'h14, C_JMP, 13'h0020);           // R8
      put_ins(8'h16, C_HLT, 13'h0000);
      put_ins(8'h20, C_STO, RAM_BASE + 13'd6);   // R10 acc still 55
      put_ins(8'h22, C_ADD, RAM_BASE + 13'd3);   // FF
      put_ins(8'h24, C_LDA, 13'h0023);           // operand taken from ROM region
      put_ins(8'h26, C_STO, RAM_BASE + 13'd7);
      put_ins(8'h28, C_HLT, 13'h0000);
      run_prog("prog1");

      // Program 2: counting loop that exits through skip-if-zero.
      for (int i = 0; i < 256; i++) rom[i] = 8'h00;
      ram[0] = 8'h00; ram[1] = 8'h01; ram[2] = 8'h05;
      put_ins(8'h00, C_LDA, RAM_BASE + 13'd0);
      put_ins(8'h02, C_ADD, RAM_BASE + 13'd1);
      put_ins(8'h04, C_STO, RAM_BASE + 13'd0);
      put_ins(8'h06, C_XOR, RAM_BASE + 13'd2);
      put_ins(8'h08, C_SKZ, 13'h0000);
      put_ins(8'h0A, C_JMP, 13'h0000);
      put_ins(8'h0C, C_HLT, 13'h0000);
      run_prog("prog2");

      // Rerun after halt: reset must restart from 0 with cleared accumulator.
      ram[0] = 8'hFA;
      run_prog("prog2_rerun");

      report();
      $finish;
   end

endmodule